// File: doc/BRIEF.md
# Card Command Response Handler

This block sits between the register front end of a memory card host and the card-side engine. A 16-bit command word is written to it. The block decodes the word's fields, issues a request carrying the command index to the card side, and then collects the response bytes that come back. When the response is complete, the block checks that the response is long enough for the response type the command announced. It tests the response for card-reported errors, using a mask that depends on that type, and raises one-cycle status set pulses. It also fills eight 16-bit response registers, which software reads back.

Commands that move data through the data FIFO emit a transfer-start pulse with the latched direction, so the data path can reset its FIFO pointers and begin. A special initialisation form of command 0 sends nothing to the card and only reports completion. Serial bus encoding and CRC checking are not part of this block.

Top module: `cmd_rsp_handler`

## Requirements
- R1: A command write (`cmd_wr`) is accepted only while `en` is high and `busy` is low. An ignored write sends no request, sets no status bit and leaves `busy` low.
- R2: In the cycle after a command is accepted, all eight response registers read zero.
- R3: An accepted word with the init flag (bit 7) set and index (bits 5:0) zero produces `sts_set` = 0x0001 in the next cycle. It raises no request, no `xfer_start`, and `busy` stays low.
- R4: Any other accepted command raises `req_valid` with `req_index` equal to word bits 5:0. Both stay stable until `req_ready` is seen.
- R5: Response type is word bits 10:8. Type 1, 3 and 6 need at least 4 bytes, and type 2 needs 16 bytes. If fewer bytes arrive, `sts_set` has bit 7 set and bits 0, 2, 12 and 14 clear, and the response registers stay zero.
- R6: For type 1, with or without the busy flag (bit 11), bytes 0..3 form a big-endian word. If that word has any bit of 0xFDF90000 set, status bit 14 is set.
- R7: For type 3, if bit 31 of the big-endian word from bytes 0..3 is clear, status bit 12 is set. Otherwise it is not.
- R8: For type 6, if the halfword {byte 2, byte 3} has any bit of 0xE008 set, status bit 14 is set. Bytes 0 and 1 have no effect on it.
- R9: On a successful response of type 1, 2, 3 or 6, register 7−k (at `rsp_regs` bits 16(7−k)+15 : 16(7−k)) receives {byte 2k, byte 2k+1}. Bytes that did not arrive read as zero, and bytes beyond the sixteenth are dropped.
- R10: A successful command with index 12 sets status bits 0 and 2. Other successful commands set bit 0 and not bit 2.
- R11: An accepted command with command type (bits 13:12) equal to 3, other than the init form of R3, pulses `xfer_start` for one cycle in the cycle after acceptance. In that same cycle, `xfer_dir` shows word bit 15.
- R12: Response types 0, 4, 5 and 7 need no bytes. They complete with status bit 0 and leave the response registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| req_valid | output | 1 | Request to card side valid |
| req_ready | input | 1 | Card side takes the request |
| req_index | output | 6 | Command index of the request |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Block accepts response beats |
| rsp_byte | input | 8 | Response byte |
| rsp_keep | input | 1 | Beat carries a byte |
| rsp_last | input | 1 | Final beat of the response |
| sts_set | output | 16 | One-cycle status set pulses |
| xfer_start | output | 1 | Data transfer start pulse |
| xfer_dir | output | 1 | Latched transfer direction |
| rsp_regs | output | 128 | Eight response registers, register j at bits 16j+15:16j |
| busy | output | 1 | Command in flight |

## Verification
The properties assume that reset is held from time zero. They also assume that the card side presents response beats only while `rsp_ready` is high, and ends every response with exactly one beat that has `rsp_last` set. A zero-length response is one beat with `rsp_keep` low. The bench's card model honours these rules. It answers a request only after `req_valid` is seen, streams bytes only after the request handshake, and closes each response with a single last beat. It also stretches `req_ready` to exercise request holding.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  localparam logic [2:0] RT_NONE  = 3'd0;
  localparam logic [2:0] RT_SHORT = 3'd1;
  localparam logic [2:0] RT_LONG  = 3'd2;
  localparam logic [2:0] RT_OCR   = 3'd3;
  localparam logic [2:0] RT_RCA   = 3'd6;

  localparam logic [1:0] CT_DATA  = 2'd3;

  localparam int STS_DONE     = 0;
  localparam int STS_STOP     = 2;
  localparam int STS_TIMEOUT  = 7;
  localparam int STS_OCR_BUSY = 12;
  localparam int STS_CARD_ERR = 14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RESP,
    ST_DONE
  } hstate_t;

  typedef struct packed {
    logic [5:0] idx;
    logic       init0;
    logic       data_xfer;
    logic       dir;
    logic [2:0] rtype;
  } cmd_dec_t;

endpackage

// File: rtl/cmdrsp_decode.sv
module cmdrsp_decode
  import cmdrsp_pkg::*;
(
  input  logic [15:0] word_i,
  output cmd_dec_t    dec_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[14], word_i[11], word_i[6]};

  always_comb begin
    dec_o.idx       = word_i[5:0];
    dec_o.init0     = word_i[7] && (word_i[5:0] == 6'd0);
    dec_o.data_xfer = (word_i[13:12] == CT_DATA);
    dec_o.dir       = word_i[15];
    // busy variant of type 1 is classified like plain type 1
    dec_o.rtype     = word_i[10:8];
  end
endmodule

// File: rtl/cmdrsp_capture.sv
module cmdrsp_capture #(
  parameter int N_BYTES = 16,
  localparam int CNT_W  = $clog2(N_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 beat,
  input  logic [7:0]           byte_in,
  output logic [8*N_BYTES-1:0] bytes_o,
  output logic [CNT_W-1:0]     cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_o <= '0;
    else if (beat && cnt_o != CNT_W'(N_BYTES))
      cnt_o <= cnt_o + 1'b1;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr)
        bytes_o[8*g +: 8] <= '0;
      else if (beat && cnt_o == CNT_W'(g))
        bytes_o[8*g +: 8] <= byte_in;
    end
  end
endmodule

// File: rtl/cmdrsp_classify.sv
module cmdrsp_classify
  import cmdrsp_pkg::*;
#(
  parameter int          N_BYTES  = 16,
  parameter logic [31:0] R1_MASK  = 32'hFDF9_0000,
  parameter logic [15:0] R6_MASK  = 16'hE008,
  parameter int          STOP_IDX = 12,
  localparam int CNT_W = $clog2(N_BYTES + 1),
  localparam int N_HW  = N_BYTES / 2
) (
  input  logic [5:0]           idx_i,
  input  logic [2:0]           rtype_i,
  input  logic [8*N_BYTES-1:0] bytes_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [15:0]          set_o,
  output logic                 store_o,
  output logic [8*N_BYTES-1:0] hw_o
);
  logic [CNT_W-1:0] need;
  logic             short_rsp;
  logic [31:0]      word32;

  assign word32 = {bytes_i[7:0], bytes_i[15:8], bytes_i[23:16], bytes_i[31:24]};

  always_comb begin
    unique case (rtype_i)
      RT_SHORT, RT_OCR, RT_RCA: need = CNT_W'(4);
      RT_LONG:                  need = CNT_W'(N_BYTES);
      default:                  need = '0;
    endcase
    short_rsp = (need != '0) && (cnt_i < need);
    store_o   = (need != '0) && !short_rsp;

    set_o = '0;
    if (short_rsp) begin
      set_o[STS_TIMEOUT] = 1'b1;
    end else begin
      set_o[STS_DONE] = 1'b1;
      if (idx_i == 6'(STOP_IDX)) set_o[STS_STOP] = 1'b1;
      unique case (rtype_i)
        RT_SHORT: if (|(word32 & R1_MASK))        set_o[STS_CARD_ERR] = 1'b1;
        RT_OCR:   if (!word32[31])                set_o[STS_OCR_BUSY] = 1'b1;
        RT_RCA:   if (|(word32[15:0] & R6_MASK))  set_o[STS_CARD_ERR] = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_HW; k++) begin : g_hw
    assign hw_o[16*(N_HW-1-k) +: 16] = {bytes_i[16*k +: 8], bytes_i[16*k+8 +: 8]};
  end
endmodule

// File: rtl/cmd_rsp_handler.sv
module cmd_rsp_handler
  import cmdrsp_pkg::*;
#(
  parameter int          RSP_BYTES = 16,
  parameter logic [31:0] R1_MASK   = 32'hFDF9_0000,
  parameter logic [15:0] R6_MASK   = 16'hE008,
  parameter int          STOP_IDX  = 12,
  localparam int CNT_W = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   cmd_wr,
  input  logic [15:0]            cmd_word,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [5:0]             req_index,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [7:0]             rsp_byte,
  input  logic                   rsp_keep,
  input  logic                   rsp_last,
  output logic [15:0]            sts_set,
  output logic                   xfer_start,
  output logic                   xfer_dir,
  output logic [8*RSP_BYTES-1:0] rsp_regs,
  output logic                   busy
);
  hstate_t                state;
  cmd_dec_t               dec;
  logic [5:0]             cur_idx;
  logic [2:0]             cur_rt;
  logic                   accept;
  logic                   beat;
  logic [8*RSP_BYTES-1:0] cap_bytes;
  logic [CNT_W-1:0]       cap_cnt;
  logic [15:0]            cls_set;
  logic                   cls_store;
  logic [8*RSP_BYTES-1:0] cls_hw;

  cmdrsp_decode u_dec (.word_i(cmd_word), .dec_o(dec));

  assign accept    = cmd_wr && en && (state == ST_IDLE);
  assign beat      = (state == ST_RESP) && rsp_valid && rsp_keep;
  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_RESP);
  assign busy      = (state != ST_IDLE);
  assign req_index = cur_idx;

  cmdrsp_capture #(.N_BYTES(RSP_BYTES)) u_cap (
    .clk(clk), .rst(rst), .clr(accept), .beat(beat), .byte_in(rsp_byte),
    .bytes_o(cap_bytes), .cnt_o(cap_cnt)
  );

  cmdrsp_classify #(
    .N_BYTES(RSP_BYTES), .R1_MASK(R1_MASK), .R6_MASK(R6_MASK), .STOP_IDX(STOP_IDX)
  ) u_cls (
    .idx_i(cur_idx), .rtype_i(cur_rt), .bytes_i(cap_bytes), .cnt_i(cap_cnt),
    .set_o(cls_set), .store_o(cls_store), .hw_o(cls_hw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_idx    <= '0;
      cur_rt     <= '0;
      sts_set    <= '0;
      xfer_start <= 1'b0;
      xfer_dir   <= 1'b0;
      rsp_regs   <= '0;
    end else begin
      sts_set    <= '0;
      xfer_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            rsp_regs <= '0;
            cur_idx  <= dec.idx;
            cur_rt   <= dec.rtype;
            if (dec.init0) begin
              sts_set[STS_DONE] <= 1'b1;
            end else begin
              state <= ST_REQ;
              if (dec.data_xfer) begin
                xfer_start <= 1'b1;
                xfer_dir   <= dec.dir;
              end
            end
          end
        end
        ST_REQ:  if (req_ready) state <= ST_RESP;
        ST_RESP: if (rsp_valid && rsp_last) state <= ST_DONE;
        ST_DONE: begin
          sts_set <= cls_set;
          if (cls_store) rsp_regs <= cls_hw;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_rsp_handler_chk.sv
module cmd_rsp_handler_chk #(
  parameter int RSP_BYTES = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic                   cmd_wr,
  input logic [15:0]            cmd_word,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [5:0]             req_index,
  input logic [15:0]            sts_set,
  input logic                   xfer_start,
  input logic [8*RSP_BYTES-1:0] rsp_regs,
  input logic                   busy
);
  AST_IGNORE_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !en && !busy) |=> (!busy && sts_set == 16'h0)); // R1
  AST_ACCEPT_CLR: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && en && !busy) |=> (rsp_regs == '0)); // R2
  AST_INIT_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && en && !busy && cmd_word[7] && cmd_word[5:0] == 6'd0)
      |=> (!busy && sts_set == 16'h0001)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index))); // R4
  AST_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    sts_set[7] |-> (!sts_set[0] && !sts_set[14] && !sts_set[12])); // R5
  AST_STOP_PAIR: assert property (@(posedge clk) disable iff (rst)
    sts_set[2] |-> sts_set[0]); // R10
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R11
endmodule

bind cmd_rsp_handler cmd_rsp_handler_chk #(.RSP_BYTES(RSP_BYTES)) chk_i (
  .clk(clk), .rst(rst), .en(en), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
  .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
  .sts_set(sts_set), .xfer_start(xfer_start), .rsp_regs(rsp_regs), .busy(busy)
);

// File: tb/cmd_rsp_handler_tb_top.sv
module cmd_rsp_handler_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [15:0]  cmd_word = '0;
  logic         req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [7:0]   rsp_byte = '0;
  logic         rsp_keep = 1'b0, rsp_last = 1'b0;
  logic [15:0]  sts_set;
  logic         xfer_start, xfer_dir, busy;
  logic [127:0] rsp_regs;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmd_rsp_handler dut_i (
    .clk(clk), .rst(rst), .en(en), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .rsp_keep(rsp_keep), .rsp_last(rsp_last), .sts_set(sts_set),
    .xfer_start(xfer_start), .xfer_dir(xfer_dir), .rsp_regs(rsp_regs), .busy(busy)
  );

  typedef struct packed {
    logic [15:0]  w;
    logic [4:0]   n;
    logic [127:0] b;
    logic [15:0]  sts;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0111, 5'd4,  128'h0009_0000, 16'h0001},   // type 1 clean
    '{16'h0911, 5'd4,  128'h0000_0080, 16'h4001},   // type 1 busy, error bit 31
    '{16'h0111, 5'd3,  128'h0003_0201, 16'h0080},   // type 1 short
    '{16'h0301, 5'd4,  128'h4433_ff00, 16'h1001},   // type 3, bit 31 clear
    '{16'h0301, 5'd4,  128'h0000_0080, 16'h0001},   // type 3, bit 31 set
    '{16'h0202, 5'd16, 128'h0f0e0d0c0b0a09080706050403020100, 16'h0001},
    '{16'h0202, 5'd15, 128'h000e0d0c0b0a09080706050403020100, 16'h0080},
    '{16'h0603, 5'd4,  128'h0020_ffff, 16'h4001},   // type 6 error in byte 2
    '{16'h0603, 5'd4,  128'h0100_abcd, 16'h0001},   // type 6 clean
    '{16'h010c, 5'd4,  128'h0,         16'h0005},   // index 12
    '{16'h0505, 5'd4,  128'h0403_0201, 16'h0001}    // type 5, no length needed
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_regs(input logic [15:0] w, input int n,
                                            input logic [127:0] b, input logic [15:0] st);
    logic [127:0] r = '0;
    logic [2:0]   rt = w[10:8];
    if (st[7] || !(rt == 3'd1 || rt == 3'd2 || rt == 3'd3 || rt == 3'd6)) return r;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] hi = (2*k < n)     ? b[16*k +: 8]   : 8'h00;
      logic [7:0] lo = (2*k + 1 < n) ? b[16*k+8 +: 8] : 8'h00;
      r[16*(7-k) +: 16] = {hi, lo};
    end
    return r;
  endfunction

  task automatic run_cmd(input logic [15:0] w, input int n, input logic [127:0] b,
                         input int dly, output logic [15:0] st, output logic [127:0] rg,
                         output logic xs, output logic xd);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk); cmd_wr = 1'b0;
    chk(rsp_regs == '0, "R2 regs cleared on accept", rsp_regs, 128'h0);
    xs = xfer_start; xd = xfer_dir;
    st = sts_set; rg = rsp_regs;
    if (w[7] && w[5:0] == 6'd0) return;
    chk(req_valid && req_index == w[5:0], "R4 request index",
        {req_valid, req_index}, {1'b1, w[5:0]});
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(req_valid && req_index == w[5:0], "R4 request held",
          {req_valid, req_index}, {1'b1, w[5:0]});
    end
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    if (n == 0) begin
      rsp_valid = 1'b1; rsp_keep = 1'b0; rsp_last = 1'b1; @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        rsp_valid = 1'b1; rsp_keep = 1'b1; rsp_last = (i == n - 1);
        rsp_byte = (i < 16) ? b[8*i +: 8] : 8'hEE;
        @(negedge clk);
      end
    end
    rsp_valid = 1'b0; rsp_keep = 1'b0; rsp_last = 1'b0;
    @(negedge clk);
    st = sts_set; rg = rsp_regs;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0]  st;
    logic [127:0] rg;
    logic         xs, xd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !req_valid && sts_set == 0 && rsp_regs == 0 && !xfer_start,
        "R1 reset state", {busy, req_valid, xfer_start, sts_set}, 0);

    // R1: disabled controller ignores writes
    cmd_wr = 1'b1; cmd_word = 16'h0111; @(negedge clk); cmd_wr = 1'b0;
    chk(!busy && !req_valid, "R1 ignored while disabled", {busy, req_valid}, 0);
    @(negedge clk);
    chk(sts_set == 0, "R1 no status while disabled", sts_set, 0);
    en = 1'b1;

    // table walk: R5 R6 R7 R8 R10 R12 status, R9 register layout
    for (int v = 0; v < NV; v++) begin
      run_cmd(VECS[v].w, int'(VECS[v].n), VECS[v].b, v % 3, st, rg, xs, xd);
      chk(st == VECS[v].sts, "R5 R6 R7 R8 R10 R12 status", st, VECS[v].sts);
      chk(rg == exp_regs(VECS[v].w, int'(VECS[v].n), VECS[v].b, VECS[v].sts),
          "R9 response registers", rg,
          exp_regs(VECS[v].w, int'(VECS[v].n), VECS[v].b, VECS[v].sts));
    end

    // R12: zero-length response for type 0
    run_cmd(16'h0005, 0, 128'h0, 0, st, rg, xs, xd);
    chk(st == 16'h0001 && rg == 0, "R12 no response type", {st, rg[15:0]}, {16'h0001, 16'h0});

    // R9: overlong type 2, extra bytes dropped
    run_cmd(16'h0202, 18, 128'hff0e0d0c0b0a09080706050403020111, 0, st, rg, xs, xd);
    chk(rg == exp_regs(16'h0202, 16, 128'hff0e0d0c0b0a09080706050403020111, 16'h0001),
        "R9 overlong response", rg,
        exp_regs(16'h0202, 16, 128'hff0e0d0c0b0a09080706050403020111, 16'h0001));

    // R3: init form of command 0, even with data command type
    run_cmd(16'h3080, 0, 128'h0, 0, st, rg, xs, xd);
    chk(st == 16'h0001, "R3 init status", st, 16'h0001);
    chk(!busy && !req_valid && !xs, "R3 no request no transfer",
        {busy, req_valid, xs}, 0);

    // R11: data command read direction
    @(negedge clk); cmd_wr = 1'b1; cmd_word = 16'hB111;
    @(negedge clk); cmd_wr = 1'b0;
    chk(xfer_start && xfer_dir, "R11 start with dir 1", {xfer_start, xfer_dir}, 2'b11);
    // R1: a write while busy is ignored
    cmd_wr = 1'b1; cmd_word = 16'h0122;
    @(negedge clk); cmd_wr = 1'b0;
    chk(!xfer_start && req_index == 6'h11, "R1 R11 busy write ignored, pulse ends",
        {xfer_start, req_index}, {1'b0, 6'h11});
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_keep = 1'b1; rsp_last = 1'b0; rsp_byte = 8'h00;
    repeat (3) @(negedge clk);
    rsp_last = 1'b1; @(negedge clk);
    rsp_valid = 1'b0; rsp_keep = 1'b0; rsp_last = 1'b0;
    @(negedge clk);
    chk(sts_set == 16'h0001, "R10 data command completes", sts_set, 16'h0001);

    // R11: data command write direction
    run_cmd(16'h3111, 4, 128'h0, 1, st, rg, xs, xd);
    chk(xs && !xd, "R11 start with dir 0", {xs, xd}, 2'b10);
    // R11: non-data command gives no pulse
    run_cmd(16'h2111, 4, 128'h0, 0, st, rg, xs, xd);
    chk(!xs, "R11 no pulse for non-data type", xs, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule